// File: doc/BRIEF.md
# Dual-Regime Turbine Pulse Rate Meter

This block turns the raw pulse train of a turbine sensor into a rate figure that stays accurate from a trickle to full flow. The incoming signal is synchronised, then debounced by a filter that accepts a new level only after it has held steady for a programmable number of reference clocks. Every excursion shorter than that is thrown away and counted. Accepted high pulses narrower than a programmable minimum are counted as width violations.

At low rates the meter reports the number of reference clocks between consecutive clean rising edges. At high rates it reports how many clean rising edges fell inside a fixed gate window. The meter moves from period mode to gate mode when a measured period is shorter than one threshold. It moves back when a gate count is smaller than a second, independent threshold. The gap between the two thresholds is a hysteresis band in which the current mode holds. Each result comes with a one-bit mode tag and a one-cycle valid strobe.

Saturating diagnostic counters record rejected bounces, width violations and counter overflows. A stuck flag reports an input that has not moved for longer than a programmable limit.

Top module: `turbine_pulse_meter`

## Requirements
- R1: A level change on `pulse_in` is accepted only after the synchronised input has differed from the accepted level for `cfg_debounce_len` consecutive clocks (0 acts as 1). A shorter excursion produces no edge and adds one to `bounce_reject_cnt`.
- R2: When an accepted high pulse lasts fewer than `cfg_min_width` clocks, `width_viol_cnt` increases by one on its falling edge. Wider pulses leave it unchanged.
- R3: In period mode (tag `result_mode`=0), a result is the number of clocks between two consecutive clean rising edges.
- R4: In gate mode (tag `result_mode`=1), a result is the number of clean rising edges within a window of `cfg_gate_len` clocks (values below 2 act as 2). Windows follow each other back to back.
- R5: A period result below `cfg_enter_gate_period` switches the meter to gate mode. A gate result below `cfg_leave_gate_count` switches it to period mode. In every other case the mode is kept.
- R6: After a switch, the first result of the new mode covers one complete measurement. The first gate result arrives one full window after the switching period result. Period mode needs two rising edges before it gives its first result.
- R7: An overflow adds exactly one to `overflow_cnt` for each event, and the affected measurement yields no wrapped value. An overflow is a period count reaching all ones with no edge, or an edge count already at all ones. After a period overflow, the next rising edge only starts a fresh period.
- R8: `stuck_flag` is high while the number of clocks since the last clean edge exceeds `cfg_stuck_limit`. It clears after the next clean edge.
- R9: `result_valid` is high for one clock per result. `result` and `result_mode` hold their values between results.
- R10: The diagnostic counters saturate at all ones and do not wrap.
- R11: After reset, `result_valid`, `result_mode`, `stuck_flag` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Raw turbine pulse, asynchronous |
| cfg_debounce_len | input | DB_W | Clocks a new level must hold to be accepted |
| cfg_min_width | input | CNT_W | Minimum legal high width in clocks |
| cfg_stuck_limit | input | CNT_W | Clocks without an edge before the stuck flag rises |
| cfg_gate_len | input | CNT_W | Gate window length in clocks |
| cfg_enter_gate_period | input | CNT_W | Period below which gate mode is entered |
| cfg_leave_gate_count | input | CNT_W | Gate count below which period mode is re-entered |
| result | output | CNT_W | Period in clocks or edge count |
| result_mode | output | 1 | 0 = period result, 1 = gate result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| bounce_reject_cnt | output | DIAG_W | Rejected short excursions |
| width_viol_cnt | output | DIAG_W | Accepted pulses narrower than the minimum |
| overflow_cnt | output | DIAG_W | Period or edge counter overflow events |
| stuck_flag | output | 1 | Input idle beyond the limit |

## Verification
A clean edge appears inside the block 2 + `cfg_debounce_len` clocks after the raw change. A period result is strobed one clock after the closing edge, and a gate result one clock after the last cycle of its window. Because both edges of a pulse are delayed by the same amount, the bench never relies on absolute latency. It waits for the strobe, sampled on the falling clock edge. It compares values, and it compares the spacing between strobes, such as exactly one window between the switching period result and the first gate result. Diagnostic counters and the stuck flag are read only after a settling margin of well over the edge latency.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic {
        MODE_PERIOD = 1'b0,
        MODE_GATE   = 1'b1
    } meter_mode_e;

endpackage

// File: rtl/tpm_debounce.sv
module tpm_debounce #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_in,
    input  logic [DB_W-1:0] cfg_len,
    output logic            level,
    output logic            rise,
    output logic            fall,
    output logic            reject
);

    typedef struct packed {
        logic            sync1;
        logic            sync2;
        logic            lvl;
        logic [DB_W-1:0] cnt;
        logic            rise;
        logic            fall;
        logic            rej;
    } db_state_t;

    db_state_t q, d;

    logic [DB_W-1:0] len_eff;
    logic [DB_W:0]   cnt_inc;

    always_comb begin
        d        = q;
        d.rise   = 1'b0;
        d.fall   = 1'b0;
        d.rej    = 1'b0;
        d.sync1  = raw_in;
        d.sync2  = q.sync1;
        len_eff  = (cfg_len == '0) ? DB_W'(1) : cfg_len;
        cnt_inc  = {1'b0, q.cnt} + (DB_W+1)'(1);
        if (q.sync2 == q.lvl) begin
            // excursion ended before it was accepted
            if (q.cnt != '0) begin
                d.rej = 1'b1;
            end
            d.cnt = '0;
        end else if (cnt_inc >= {1'b0, len_eff}) begin
            d.lvl  = q.sync2;
            d.cnt  = '0;
            d.rise = q.sync2;
            d.fall = ~q.sync2;
        end else begin
            d.cnt = cnt_inc[DB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level  = q.lvl;
    assign rise   = q.rise;
    assign fall   = q.fall;
    assign reject = q.rej;

    // R1: an accepted level was present on the synchronised input before
    assert_level_from_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl != $past(q.lvl)) |-> ($past(q.sync2) == q.lvl));

    // R1: a rejection only follows an input that returned to the held level
    assert_reject_after_return_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.rej |-> ($past(q.sync2) == $past(q.lvl)));

endmodule

// File: rtl/tpm_pulse_check.sv
module tpm_pulse_check #(
    parameter int CNT_W  = 16,
    parameter int DIAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic              rise,
    input  logic              fall,
    input  logic [CNT_W-1:0]  cfg_min_width,
    input  logic [CNT_W-1:0]  cfg_stuck_limit,
    output logic [DIAG_W-1:0] width_viol_cnt,
    output logic              stuck_flag
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [DIAG_W-1:0] DIAG_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  wid;
        logic [CNT_W-1:0]  idle;
        logic [DIAG_W-1:0] viol;
    } pc_state_t;

    pc_state_t q, d;

    always_comb begin
        d = q;
        // width of the current clean high phase
        if (level) begin
            if (q.wid != CNT_MAX) begin
                d.wid = q.wid + CNT_W'(1);
            end
        end else begin
            d.wid = '0;
        end
        if (fall && (q.wid < cfg_min_width) && (q.viol != DIAG_MAX)) begin
            d.viol = q.viol + DIAG_W'(1);
        end
        // time since the last clean edge
        if (rise || fall) begin
            d.idle = '0;
        end else if (q.idle != CNT_MAX) begin
            d.idle = q.idle + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign width_viol_cnt = q.viol;
    assign stuck_flag     = (q.idle > cfg_stuck_limit);

    // R2: the violation counter moves only on a falling edge
    assert_viol_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.viol != $past(q.viol)) |-> $past(fall));

    // R10: the violation counter never wraps to zero
    assert_viol_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.viol) == DIAG_MAX) |-> (q.viol == DIAG_MAX));

    // R8: the stuck flag only drops after a clean edge
    assert_stuck_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stuck_flag) && $stable(cfg_stuck_limit)) |-> $past(rise || fall));

endmodule

// File: rtl/tpm_measure.sv
module tpm_measure
    import tpm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic [CNT_W-1:0]  cfg_gate_len,
    input  logic [CNT_W-1:0]  cfg_enter_gate_period,
    input  logic [CNT_W-1:0]  cfg_leave_gate_count,
    output logic [CNT_W-1:0]  result,
    output logic              result_mode,
    output logic              result_valid,
    output logic [DIAG_W-1:0] overflow_cnt
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [DIAG_W-1:0] DIAG_MAX = '1;

    typedef struct packed {
        meter_mode_e       mode;
        logic              have_ref;
        logic [CNT_W-1:0]  per;
        logic              per_sat;
        logic [CNT_W-1:0]  gtim;
        logic [CNT_W-1:0]  ecnt;
        logic              ecnt_sat;
        logic [CNT_W-1:0]  res;
        meter_mode_e       res_mode;
        logic              valid;
        logic [DIAG_W-1:0] ovf;
    } ms_state_t;

    ms_state_t q, d;

    logic [CNT_W-1:0] gate_len_eff;
    logic             gate_last;
    logic [CNT_W-1:0] e_next;
    logic             e_sat;
    logic             ovf_evt;

    always_comb begin
        d            = q;
        d.valid      = 1'b0;
        ovf_evt      = 1'b0;
        gate_len_eff = (cfg_gate_len < CNT_W'(2)) ? CNT_W'(2) : cfg_gate_len;
        gate_last    = (q.gtim >= (gate_len_eff - CNT_W'(1)));
        e_next       = q.ecnt;
        e_sat        = q.ecnt_sat;

        if (q.mode == MODE_PERIOD) begin
            if (rise) begin
                d.have_ref = 1'b1;
                d.per      = CNT_W'(1);
                d.per_sat  = 1'b0;
                if (q.have_ref && !q.per_sat) begin
                    d.res      = q.per;
                    d.res_mode = MODE_PERIOD;
                    d.valid    = 1'b1;
                    if (q.per < cfg_enter_gate_period) begin
                        d.mode     = MODE_GATE;
                        d.have_ref = 1'b0;
                        d.gtim     = '0;
                        d.ecnt     = '0;
                        d.ecnt_sat = 1'b0;
                    end
                end
            end else if (!q.per_sat) begin
                if (q.per == CNT_MAX) begin
                    ovf_evt   = 1'b1;
                    d.per_sat = 1'b1;
                end else begin
                    d.per = q.per + CNT_W'(1);
                end
            end
        end else begin
            if (rise) begin
                if (q.ecnt == CNT_MAX) begin
                    ovf_evt = ~q.ecnt_sat;
                    e_sat   = 1'b1;
                end else begin
                    e_next = q.ecnt + CNT_W'(1);
                end
            end
            if (gate_last) begin
                d.res      = e_next;
                d.res_mode = MODE_GATE;
                d.valid    = 1'b1;
                d.gtim     = '0;
                d.ecnt     = '0;
                d.ecnt_sat = 1'b0;
                if (e_next < cfg_leave_gate_count) begin
                    d.mode     = MODE_PERIOD;
                    d.have_ref = 1'b0;
                    d.per      = '0;
                    d.per_sat  = 1'b0;
                end
            end else begin
                d.gtim     = q.gtim + CNT_W'(1);
                d.ecnt     = e_next;
                d.ecnt_sat = e_sat;
            end
        end

        if (ovf_evt && (q.ovf != DIAG_MAX)) begin
            d.ovf = q.ovf + DIAG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign result       = q.res;
    assign result_mode  = q.res_mode;
    assign result_valid = q.valid;
    assign overflow_cnt = q.ovf;

    // R9: one strobe per result
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R9: outputs hold between results
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> ($stable(q.res) && $stable(q.res_mode)));

    // R5: mode changes only together with a result
    assert_mode_at_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != $past(q.mode)) |-> q.valid);

    // R5: a period result inside the band keeps period mode
    assert_hold_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && (q.res_mode == MODE_PERIOD) && (q.res >= $past(cfg_enter_gate_period)))
        |-> (q.mode == MODE_PERIOD));

    // R5: a gate result inside the band keeps gate mode
    assert_hold_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && (q.res_mode == MODE_GATE) && (q.res >= $past(cfg_leave_gate_count)))
        |-> (q.mode == MODE_GATE));

    // R4: the tag reflects the mode that made the measurement
    assert_result_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> (q.res_mode == $past(q.mode)));

    // R7: overflow counter moves by one step at a time
    assert_no_overflow_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf != $past(q.ovf)) |-> (q.ovf == ($past(q.ovf) + DIAG_W'(1))));

endmodule

// File: rtl/turbine_pulse_meter.sv
module turbine_pulse_meter #(
    parameter int CNT_W  = 16,
    parameter int DIAG_W = 16,
    parameter int DB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [DB_W-1:0]   cfg_debounce_len,
    input  logic [CNT_W-1:0]  cfg_min_width,
    input  logic [CNT_W-1:0]  cfg_stuck_limit,
    input  logic [CNT_W-1:0]  cfg_gate_len,
    input  logic [CNT_W-1:0]  cfg_enter_gate_period,
    input  logic [CNT_W-1:0]  cfg_leave_gate_count,
    output logic [CNT_W-1:0]  result,
    output logic              result_mode,
    output logic              result_valid,
    output logic [DIAG_W-1:0] bounce_reject_cnt,
    output logic [DIAG_W-1:0] width_viol_cnt,
    output logic [DIAG_W-1:0] overflow_cnt,
    output logic              stuck_flag
);

    localparam logic [DIAG_W-1:0] DIAG_MAX = '1;

    logic clean_lvl;
    logic clean_rise;
    logic clean_fall;
    logic bounce;

    typedef struct packed {
        logic [DIAG_W-1:0] rej;
    } top_state_t;

    top_state_t q, d;

    tpm_debounce #(
        .DB_W (DB_W)
    ) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (pulse_in),
        .cfg_len (cfg_debounce_len),
        .level   (clean_lvl),
        .rise    (clean_rise),
        .fall    (clean_fall),
        .reject  (bounce)
    );

    tpm_pulse_check #(
        .CNT_W  (CNT_W),
        .DIAG_W (DIAG_W)
    ) u_pulse_check (
        .clk             (clk),
        .rst_n           (rst_n),
        .level           (clean_lvl),
        .rise            (clean_rise),
        .fall            (clean_fall),
        .cfg_min_width   (cfg_min_width),
        .cfg_stuck_limit (cfg_stuck_limit),
        .width_viol_cnt  (width_viol_cnt),
        .stuck_flag      (stuck_flag)
    );

    tpm_measure #(
        .CNT_W  (CNT_W),
        .DIAG_W (DIAG_W)
    ) u_measure (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .rise                  (clean_rise),
        .cfg_gate_len          (cfg_gate_len),
        .cfg_enter_gate_period (cfg_enter_gate_period),
        .cfg_leave_gate_count  (cfg_leave_gate_count),
        .result                (result),
        .result_mode           (result_mode),
        .result_valid          (result_valid),
        .overflow_cnt          (overflow_cnt)
    );

    always_comb begin
        d = q;
        if (bounce && (q.rej != DIAG_MAX)) begin
            d.rej = q.rej + DIAG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bounce_reject_cnt = q.rej;

    // R1: a rejected excursion never produces a clean edge in the same cycle
    assert_reject_no_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bounce |-> !(clean_rise || clean_fall));

    // R10: reject counter holds at all ones
    assert_reject_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.rej) == DIAG_MAX) |-> (q.rej == DIAG_MAX));

endmodule

// File: tb/test_turbine_pulse_meter.sv
module test_turbine_pulse_meter;

    localparam int CNT_W  = 12;
    localparam int DIAG_W = 4;
    localparam int DB_W   = 8;
    localparam int GATE   = 240;

    // period, high time, expected tag, expected steady result
    localparam int VEC_N = 6;
    localparam int VEC [VEC_N][4] = '{
        '{100, 50, 0, 100},
        '{ 80, 20, 0,  80},
        '{ 48, 24, 0,  48},
        '{ 30, 15, 1,   8},
        '{ 48, 24, 1,   5},
        '{120, 60, 0, 120}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_in = 1'b0;
    logic [DB_W-1:0]   cfg_debounce_len = 8'd3;
    logic [CNT_W-1:0]  cfg_min_width = 12'd4;
    logic [CNT_W-1:0]  cfg_stuck_limit = 12'd1000;
    logic [CNT_W-1:0]  cfg_gate_len = 12'(GATE);
    logic [CNT_W-1:0]  cfg_enter_gate_period = 12'd40;
    logic [CNT_W-1:0]  cfg_leave_gate_count = 12'd4;
    logic [CNT_W-1:0]  result;
    logic              result_mode;
    logic              result_valid;
    logic [DIAG_W-1:0] bounce_reject_cnt;
    logic [DIAG_W-1:0] width_viol_cnt;
    logic [DIAG_W-1:0] overflow_cnt;
    logic              stuck_flag;

    turbine_pulse_meter #(
        .CNT_W  (CNT_W),
        .DIAG_W (DIAG_W),
        .DB_W   (DB_W)
    ) i_turbine_pulse_meter (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .pulse_in              (pulse_in),
        .cfg_debounce_len      (cfg_debounce_len),
        .cfg_min_width         (cfg_min_width),
        .cfg_stuck_limit       (cfg_stuck_limit),
        .cfg_gate_len          (cfg_gate_len),
        .cfg_enter_gate_period (cfg_enter_gate_period),
        .cfg_leave_gate_count  (cfg_leave_gate_count),
        .result                (result),
        .result_mode           (result_mode),
        .result_valid          (result_valid),
        .bounce_reject_cnt     (bounce_reject_cnt),
        .width_viol_cnt        (width_viol_cnt),
        .overflow_cnt          (overflow_cnt),
        .stuck_flag            (stuck_flag)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;
    bit reported = 0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // result monitor, sampled away from the active edge
    int res_count = 0;
    int last_res  = 0;
    int last_mode = 0;
    int last_cyc  = 0;
    bit prev_v    = 0;
    int held_res  = 0;
    int held_mode = 0;
    int hold_bad  = 0;
    int dbl_bad   = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (result_valid) begin
                if (prev_v) dbl_bad++;
                res_count++;
                last_res  = int'(result);
                last_mode = int'(result_mode);
                last_cyc  = cyc;
                held_res  = int'(result);
                held_mode = int'(result_mode);
            end else if (res_count > 0 &&
                         (int'(result) != held_res || int'(result_mode) != held_mode)) begin
                hold_bad++;
            end
            prev_v = result_valid;
        end
    end

    // pulse generator: periodic train or single shots
    int gen_p = 0;
    int gen_h = 0;
    int shot_req = 0;
    int shot_ack = 0;
    int shot_w   = 0;
    int shot_cyc = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (shot_req != shot_ack) begin
                shot_cyc = cyc;
                pulse_in = 1'b1;
                repeat (shot_w) @(negedge clk);
                pulse_in = 1'b0;
                shot_ack = shot_ack + 1;
            end else if (gen_p != 0) begin
                pulse_in = 1'b1;
                repeat (gen_h) @(negedge clk);
                pulse_in = 1'b0;
                repeat (gen_p - gen_h - 1) @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    task automatic shot(input int w);
        shot_w = w;
        shot_req = shot_req + 1;
        while (shot_ack != shot_req) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_result(output bit got);
        int start;
        start = res_count;
        got = 0;
        for (int t = 0; t < 2000; t++) begin
            @(posedge clk);
            if (res_count != start) begin
                got = 1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", cyc, 150000);
        report();
    end

    initial begin
        bit got;
        int ovf0, rej0, viol0, rc, t1, t2, c30;
        bit found;

        // R11: reset state
        repeat (4) @(negedge clk);
        check(result_valid == 0, "R11 valid", int'(result_valid), 0);
        check(result_mode == 0, "R11 mode", int'(result_mode), 0);
        check(stuck_flag == 0, "R11 stuck", int'(stuck_flag), 0);
        check(bounce_reject_cnt == 0 && width_viol_cnt == 0 && overflow_cnt == 0,
              "R11 counters", int'(bounce_reject_cnt) + int'(width_viol_cnt) + int'(overflow_cnt), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk: R3 period, R4 gate, R5 hysteresis both ways, R8 no stuck
        for (int v = 0; v < VEC_N; v++) begin
            gen_h = VEC[v][1];
            gen_p = VEC[v][0];
            for (int k = 0; k < 4; k++) wait_result(got);
            check(got, "R3/R4 result present", int'(got), 1);
            check(last_mode == VEC[v][2], "R5 mode tag", last_mode, VEC[v][2]);
            check(last_res == VEC[v][3],
                  (VEC[v][2] == 0) ? "R3 period value" : "R4 gate count", last_res, VEC[v][3]);
            @(negedge clk);
            check(stuck_flag == 0, "R8 no stuck while pulsing", int'(stuck_flag), 0);
        end

        // R6: switch into gate mode, first gate result one full window later
        gen_h = 15;
        gen_p = 30;
        found = 0;
        for (int k = 0; k < 6 && !found; k++) begin
            wait_result(got);
            if (last_mode == 0 && last_res == 30) found = 1;
        end
        check(found, "R6 switching period result", int'(found), 1);
        c30 = last_cyc;
        wait_result(got);
        check(last_mode == 1, "R6 first gate tag", last_mode, 1);
        check(last_res == 8, "R6 first gate count complete", last_res, 8);
        check(last_cyc - c30 == GATE, "R6 first gate after full window", last_cyc - c30, GATE);

        // R7/R8: idle input, period counter overflows once
        gen_p = 0;
        repeat (300) @(negedge clk);
        ovf0 = int'(overflow_cnt);
        repeat (5000) @(negedge clk);
        check(int'(overflow_cnt) == ovf0 + 1, "R7 overflow counted", int'(overflow_cnt), ovf0 + 1);
        check(stuck_flag == 1, "R8 stuck after idle", int'(stuck_flag), 1);
        repeat (5000) @(negedge clk);
        check(int'(overflow_cnt) == ovf0 + 1, "R7 overflow counted once", int'(overflow_cnt), ovf0 + 1);

        // R7: first edge after overflow only restarts the period
        rc = res_count;
        shot(10);
        t1 = shot_cyc;
        check(stuck_flag == 0, "R8 stuck clears on edge", int'(stuck_flag), 0);
        check(res_count == rc, "R7 no result from overflowed period", res_count, rc);
        repeat (280) @(negedge clk);
        shot(10);
        t2 = shot_cyc;
        check(res_count == rc + 1, "R7 one result after restart", res_count, rc + 1);
        check(last_res == t2 - t1 && last_mode == 0, "R3 period after restart", last_res, t2 - t1);

        // R1: short excursions rejected and counted, no edge produced
        rej0 = int'(bounce_reject_cnt);
        rc = res_count;
        shot(1);
        check(int'(bounce_reject_cnt) == rej0 + 1, "R1 one-cycle glitch", int'(bounce_reject_cnt), rej0 + 1);
        shot(2);
        check(int'(bounce_reject_cnt) == rej0 + 2, "R1 two-cycle glitch", int'(bounce_reject_cnt), rej0 + 2);
        check(res_count == rc, "R1 glitch gives no result", res_count, rc);

        // R2: narrow accepted pulse flagged, wide one not
        viol0 = int'(width_viol_cnt);
        shot(3);
        check(int'(bounce_reject_cnt) == rej0 + 2, "R1 held pulse accepted", int'(bounce_reject_cnt), rej0 + 2);
        check(int'(width_viol_cnt) == viol0 + 1, "R2 narrow pulse", int'(width_viol_cnt), viol0 + 1);
        shot(6);
        check(int'(width_viol_cnt) == viol0 + 1, "R2 wide pulse", int'(width_viol_cnt), viol0 + 1);

        // R1: longer programmed interval rejects a 5-cycle pulse
        cfg_debounce_len = 8'd6;
        shot(5);
        check(int'(bounce_reject_cnt) == rej0 + 3, "R1 programmable length", int'(bounce_reject_cnt), rej0 + 3);
        cfg_debounce_len = 8'd3;

        // R10: reject counter saturates
        for (int k = 0; k < 16; k++) shot(1);
        check(bounce_reject_cnt == 4'hF, "R10 saturation", int'(bounce_reject_cnt), 15);

        // R9: single-cycle strobe and held outputs across the whole run
        check(dbl_bad == 0, "R9 single-cycle valid", dbl_bad, 0);
        check(hold_bad == 0, "R9 result held", hold_bad, 0);

        report();
    end

endmodule